// File: doc/BRIEF.md
# Serial Motor Command Register Interface

This block is a write-only, three-wire serial slave that loads the two 12-bit motor control registers of a four-bridge motor driver. A host sends 16-bit words least significant bit first. Each word is shifted on a rising edge of the serial clock while the select line is high. The select, serial clock, strobe and data pins are asynchronous to the block. They pass through a two-flop synchronizer into the system clock domain, and every edge is detected there. The serial clock period must therefore be at least four system clocks.

Bits shift into a 16-bit window that keeps sliding, so the most recent sixteen bits are always held. A rising edge on the strobe copies the held word into the register that its top nibble selects. If the strobe is already high when the sixteenth bit since select rose is shifted in, the copy happens by itself at that point. Each register holds the configuration of two bridges, and the block decodes these fields into per-bridge outputs: enable, direction, a three-bit current level, and the decay mode.

Top module: `motor_cmd_serial`

## Requirements
- R1: A word is shifted in least significant bit first, one bit per rising serial clock edge. After sixteen edges, the first bit sent occupies bit 0 of the held word.
- R2: Serial clock edges that occur while select is low shift nothing and change no register.
- R3: Pauses of any length between serial clock edges are allowed while select stays high, so a word sent as two 8-bit bursts is loaded the same as a continuous one.
- R4: If more than sixteen bits are shifted, the last sixteen form the held word.
- R5: Bits 15:12 of the word are the address. Value 0 writes motor register 0 (bridges 0 and 1). Value 1 writes motor register 1 (bridges 2 and 3).
- R6: Within a register, bit 0 is the enable of the lower bridge, bit 1 its direction, bits 4:2 its current level and bit 5 its decay mode. Bits 11:6 hold the same fields for the upper bridge. Bridge b drives bridge_level[3b+2:3b].
- R7: A rising strobe edge copies the held word into the addressed register. No register changes before that edge. If the sixteenth bit is shifted in during the same cycle as the strobe edge, that bit is part of the copied word.
- R8: If the strobe is high when the sixteenth bit since select rose is shifted in, the word is copied without any strobe edge.
- R9: A word whose address is neither 0 nor 1 is discarded, and both registers keep their values.
- R10: After reset every output is 0.
- R11: The bit count saturates at sixteen, so bits beyond the sixteenth do not trigger another automatic copy. Driving select low clears the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial data, asynchronous |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_sel | input | 1 | Select; shifting is enabled while it is high |
| ser_stb | input | 1 | Strobe; a rising edge commits the held word |
| bridge_en | output | 4 | Enable for each bridge |
| bridge_dir | output | 4 | Direction for each bridge |
| bridge_level | output | 12 | Current level, 3 bits per bridge |
| bridge_decay | output | 4 | Decay mode for each bridge (0 slow, 1 mixed) |

## Verification
Two events can land in the same system cycle: the shift of the sixteenth bit and a strobe rising edge. Both pass through the same synchronizer depth. The bench provokes this by raising the serial clock and the strobe pins on the same edge after fifteen bits have been sent. It then expects exactly one commit, of a word that contains the sixteenth bit. The automatic copy and the saturated count are also exercised together: with the strobe held high, extra bits are sent after the copy and must leave the registers untouched.

// File: rtl/scmd_pkg.sv
package scmd_pkg;

    localparam int WORD_W          = 16;
    localparam int ADDR_W          = 4;
    localparam int LEVEL_W         = 3;
    localparam int NUM_REGS        = 2;
    localparam int BRIDGES_PER_REG = 2;
    localparam int NUM_BRIDGES     = NUM_REGS * BRIDGES_PER_REG;
    localparam int CFG_W           = LEVEL_W + 3;
    localparam int REG_W           = CFG_W * BRIDGES_PER_REG;
    localparam int CNT_W           = $clog2(WORD_W + 1);

    // Per-bridge configuration; packed order matches the bit layout.
    typedef struct packed {
        logic               decay;
        logic [LEVEL_W-1:0] level;
        logic               phase;
        logic               enable;
    } bridge_cfg_t;

    typedef struct packed {
        bridge_cfg_t hi;
        bridge_cfg_t lo;
    } motor_reg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        motor_reg_t        body;
    } cmd_word_t;

    function automatic logic addr_hits(input logic [ADDR_W-1:0] addr, input int idx);
        return addr == ADDR_W'(idx);
    endfunction

    function automatic logic addr_valid(input logic [ADDR_W-1:0] addr);
        return addr < ADDR_W'(NUM_REGS);
    endfunction

endpackage

// File: rtl/scmd_sync.sv
module scmd_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage[0] <= '0;
        else     stage[0] <= din;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage[s] <= '0;
                else     stage[s] <= stage[s-1];
            end
        end
    endgenerate

    assign dout = stage[STAGES-1];
endmodule

// File: rtl/scmd_shifter.sv
module scmd_shifter
    import scmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sel,
    input  logic      sclk,
    input  logic      sdata,
    input  logic      stb,
    output logic      commit,
    output cmd_word_t commit_word
);
    logic [WORD_W-1:0] win, win_nxt;
    logic [CNT_W-1:0]  cnt, cnt_nxt;
    logic              sclk_q, stb_q;
    logic              sclk_rise, stb_rise, last_bit;

    assign sclk_rise = sclk & ~sclk_q;
    assign stb_rise  = stb & ~stb_q;
    assign last_bit  = sel & sclk_rise & (cnt == CNT_W'(WORD_W - 1));

    always_comb begin
        win_nxt = win;
        cnt_nxt = cnt;
        if (!sel) begin
            cnt_nxt = '0;
        end else if (sclk_rise) begin
            win_nxt = {sdata, win[WORD_W-1:1]};
            if (cnt != CNT_W'(WORD_W)) cnt_nxt = cnt + 1'b1;
        end
    end

    assign commit      = stb_rise | (last_bit & stb);
    assign commit_word = cmd_word_t'(win_nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            win    <= '0;
            cnt    <= '0;
            sclk_q <= 1'b0;
            stb_q  <= 1'b0;
        end else begin
            win    <= win_nxt;
            cnt    <= cnt_nxt;
            sclk_q <= sclk;
            stb_q  <= stb;
        end
    end

    // R1: a new bit enters at the top of the window
    a_r1_bit_enters_msb: assert property (@(posedge clk) disable iff (rst)
        (sel && sclk && !sclk_q) |=> (win[WORD_W-1] == $past(sdata)));
    // R2: nothing shifts while deselected
    a_r2_hold_deselected: assert property (@(posedge clk) disable iff (rst)
        !sel |=> $stable(win));
    // R11: count cleared by deselect, saturates at sixteen
    a_r11_count_cleared: assert property (@(posedge clk) disable iff (rst)
        !sel |=> (cnt == '0));
    a_r11_count_saturates: assert property (@(posedge clk) disable iff (rst)
        (sel && cnt == CNT_W'(WORD_W)) |=> (cnt == CNT_W'(WORD_W)));
endmodule

// File: rtl/scmd_regbank.sv
module scmd_regbank
    import scmd_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      commit,
    input  cmd_word_t                 word,
    output motor_reg_t [NUM_REGS-1:0] regs
);
    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)                                regs[r] <= '0;
                else if (commit && addr_hits(word.addr, r)) regs[r] <= word.body;
            end
        end
    endgenerate

    // R7: registers move only on a commit
    a_r7_write_only_on_commit: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(regs));
    // R9: unmapped addresses are discarded
    a_r9_unmapped_dropped: assert property (@(posedge clk) disable iff (rst)
        (commit && !addr_valid(word.addr)) |=> $stable(regs));
    // R10: reset clears every field
    a_r10_reset_clear: assert property (@(posedge clk)
        rst |=> (regs == '0));
endmodule

// File: rtl/motor_cmd_serial.sv
module motor_cmd_serial
    import scmd_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ser_data,
    input  logic                           ser_clk,
    input  logic                           ser_sel,
    input  logic                           ser_stb,
    output logic [NUM_BRIDGES-1:0]         bridge_en,
    output logic [NUM_BRIDGES-1:0]         bridge_dir,
    output logic [NUM_BRIDGES*LEVEL_W-1:0] bridge_level,
    output logic [NUM_BRIDGES-1:0]         bridge_decay
);
    logic [3:0]                sync_q;
    logic                      commit;
    cmd_word_t                 commit_word;
    motor_reg_t [NUM_REGS-1:0] regs;

    scmd_sync #(.WIDTH(4), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ser_stb, ser_sel, ser_clk, ser_data}),
        .dout (sync_q)
    );

    scmd_shifter u_shift (
        .clk         (clk),
        .rst         (rst),
        .sel         (sync_q[2]),
        .sclk        (sync_q[1]),
        .sdata       (sync_q[0]),
        .stb         (sync_q[3]),
        .commit      (commit),
        .commit_word (commit_word)
    );

    scmd_regbank u_bank (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .word   (commit_word),
        .regs   (regs)
    );

    generate
        for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
            localparam int RIDX = b / BRIDGES_PER_REG;
            bridge_cfg_t cfg;
            if ((b % BRIDGES_PER_REG) == 0) begin : g_lo
                assign cfg = regs[RIDX].lo;
            end else begin : g_hi
                assign cfg = regs[RIDX].hi;
            end
            assign bridge_en[b]                      = cfg.enable;
            assign bridge_dir[b]                     = cfg.phase;
            assign bridge_level[b*LEVEL_W +: LEVEL_W] = cfg.level;
            assign bridge_decay[b]                   = cfg.decay;
        end
    endgenerate
endmodule

// File: tb/motor_cmd_serial_bench.sv
module motor_cmd_serial_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst = 1;
    logic ser_data = 0, ser_clk = 0, ser_sel = 0, ser_stb = 0;
    logic [3:0]  bridge_en, bridge_dir, bridge_decay;
    logic [11:0] bridge_level;

    int checks = 0, errors = 0;
    logic [11:0] m_reg [2];
    logic [15:0] m_win = '0;
    int          m_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    motor_cmd_serial u_motor_cmd_serial (
        .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk),
        .ser_sel(ser_sel), .ser_stb(ser_stb), .bridge_en(bridge_en),
        .bridge_dir(bridge_dir), .bridge_level(bridge_level),
        .bridge_decay(bridge_decay)
    );

    function automatic logic [23:0] expect_out();
        logic [3:0] en, dir, dec;
        logic [11:0] lvl;
        for (int b = 0; b < 4; b++) begin
            logic [5:0] f;
            f = m_reg[b/2][6*(b%2) +: 6];
            en[b] = f[0]; dir[b] = f[1]; lvl[3*b +: 3] = f[4:2]; dec[b] = f[5];
        end
        return {en, dir, lvl, dec};
    endfunction

    task automatic check_all(input string req);
        logic [23:0] act, exp;
        act = {bridge_en, bridge_dir, bridge_level, bridge_decay};
        exp = expect_out();
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_commit(input logic [15:0] w);
        if (w[15:12] == 4'd0) m_reg[0] = w[11:0];
        else if (w[15:12] == 4'd1) m_reg[1] = w[11:0];
    endtask

    task automatic model_shift(input logic b);
        if (ser_sel) begin
            m_win = {b, m_win[15:1]};
            if (m_cnt < 16) begin
                m_cnt++;
                if (m_cnt == 16 && ser_stb) model_commit(m_win);
            end
        end
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        wait_clk(3);
        ser_clk = 1;
        model_shift(b);
        wait_clk(4);
        ser_clk = 0;
        wait_clk(4);
    endtask

    task automatic send_bits(input logic [15:0] w, input int lo, input int hi);
        for (int i = lo; i <= hi; i++) send_bit(w[i]);
    endtask

    task automatic set_sel(input logic v);
        ser_sel = v;
        if (!v) m_cnt = 0;
        wait_clk(4);
    endtask

    task automatic pulse_stb();
        ser_stb = 1;
        model_commit(m_win);
        wait_clk(6);
        ser_stb = 0;
        wait_clk(6);
    endtask

    task automatic write_word(input logic [15:0] w);
        set_sel(1);
        send_bits(w, 0, 15);
        set_sel(0);
        pulse_stb();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] w;
        void'($urandom(32'd4242));
        m_reg[0] = '0; m_reg[1] = '0;
        wait_clk(5);
        rst = 0;
        wait_clk(3);
        check_all("R10 reset state");

        // R1 R5 R6 R7: motor register 0, not visible before strobe
        set_sel(1);
        send_bits(16'h0A5B, 0, 15);
        set_sel(0);
        wait_clk(6);
        check_all("R7 no change before strobe");
        pulse_stb();
        check_all("R1 R6 reg0 word");

        write_word(16'h1C3D);
        check_all("R5 reg1 word");

        write_word(16'h2FFF);
        check_all("R9 unmapped address dropped");
        write_word(16'hF123);
        check_all("R9 address 15 dropped");

        // R2: deselected edges ignored
        set_sel(0);
        send_bits(16'hFFFF, 0, 7);
        pulse_stb();
        check_all("R2 deselected edges");
        set_sel(1);
        send_bits(16'h0123, 0, 15);
        set_sel(0);
        pulse_stb();
        check_all("R2 word after deselected edges");

        // R3: two bursts with a long pause
        set_sel(1);
        send_bits(16'h1E96, 0, 7);
        wait_clk(80);
        send_bits(16'h1E96, 8, 15);
        set_sel(0);
        pulse_stb();
        check_all("R3 burst word");

        // R4: twenty bits, last sixteen win
        set_sel(1);
        send_bits(16'h000F, 0, 3);
        send_bits(16'h07E1, 0, 15);
        set_sel(0);
        pulse_stb();
        check_all("R4 sliding window");

        // R8 / R11: strobe held high, automatic copy then saturation
        ser_stb = 1;
        wait_clk(6);
        set_sel(1);
        send_bits(16'h1AAA, 0, 14);
        check_all("R8 no copy at 15 bits");
        send_bit(1'b0);
        check_all("R8 automatic copy");
        send_bits(16'h000F, 0, 3);
        check_all("R11 saturated count no recopy");
        set_sel(0);
        set_sel(1);
        send_bits(16'h0555, 0, 15);
        check_all("R11 count restarted after deselect");
        set_sel(0);
        ser_stb = 0;
        wait_clk(6);

        // R7 corner: sixteenth bit and strobe edge in the same cycle
        set_sel(1);
        send_bits(16'h8999, 0, 14);
        ser_data = 1'b0;
        wait_clk(3);
        ser_clk = 1; ser_stb = 1;
        m_win = {1'b0, m_win[15:1]};
        m_cnt = 16;
        model_commit(m_win);
        wait_clk(6);
        ser_clk = 0; ser_stb = 0;
        wait_clk(6);
        set_sel(0);
        check_all("R7 coincident strobe and last bit");

        // random words
        for (int i = 0; i < 40; i++) begin
            int k;
            k = $urandom_range(0, 4);
            w = 16'($urandom());
            if (k < 2) w[15:12] = 4'd0;
            else if (k < 4) w[15:12] = 4'd1;
            write_word(w);
            check_all("R5 R6 random word");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule